// File: doc/BRIEF.md
# Trace-Based Spike-Timing Plasticity Learner

This block adapts a single synaptic weight according to the relative timing of the spikes on either side of the synapse. It does not record spike times. It keeps two running traces instead, one for the input (pre-synaptic) side and one for the output (post-synaptic) side. A spike on a side bumps that side's trace by a fixed step. A periodic decay tick shifts each trace right by its own configurable amount, so each trace falls off roughly exponentially between ticks.

When an output spike arrives, the weight grows by an amount scaled from the input trace. This rewards inputs that fired shortly before the output. When an input spike arrives, the weight shrinks by an amount scaled from the output trace. This penalises inputs that fire after the output. Each direction has its own gain and its own decay shift, so the strength and the time constant can be set apart for growth and for decay of the weight. Every weight change is a read-modify-write that clips at zero and at full scale. A learning enable freezes the weight while the traces keep running.

Top module: `stdp_synapse_learner`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `weight` equals WEIGHT_INIT (128 by default), and both traces are 0.
- R2: A spike on `pre_spike` (or `post_spike`) adds TRACE_STEP (64 by default) to the matching trace one clock later. The sum clips at 2^TRACE_W-1 (255 by default).
- R3: On a cycle with `decay_tick` high, the input trace is replaced by itself shifted right by `pre_shift`, and the output trace by itself shifted right by `post_shift`. If a spike lands in the same cycle, the step is added after the shift. With no spike and no tick, a trace holds.
- R4: A `post_spike` with `learn_en` high raises `weight` by floor(pre_trace * pot_gain / 2^GAIN_SHIFT), with GAIN_SHIFT=4 by default. The value of `pre_trace` used is the one before that clock edge. The result clips at 2^WEIGHT_W-1.
- R5: A `pre_spike` with `learn_en` high lowers `weight` by floor(post_trace * dep_gain / 2^GAIN_SHIFT). The value of `post_trace` used is the one before that clock edge. The result clips at 0 and never wraps.
- R6: When both spikes arrive in one cycle, the decrease is applied first and clipped, then the increase is applied and clipped. Both amounts use the trace values from before that edge.
- R7: With `learn_en` low, `weight` holds, while both traces still bump and decay as in R2 and R3.
- R8: In a cycle with neither spike, `weight` holds, even when `decay_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| learn_en | input | 1 | Allows weight updates |
| pre_spike | input | 1 | Input-side spike pulse, one cycle |
| post_spike | input | 1 | Output-side spike pulse, one cycle |
| decay_tick | input | 1 | Decay step strobe for both traces |
| pre_shift | input | SHIFT_W | Right-shift per tick for the input trace |
| post_shift | input | SHIFT_W | Right-shift per tick for the output trace |
| pot_gain | input | GAIN_W | Gain applied to the input trace for weight increase |
| dep_gain | input | GAIN_W | Gain applied to the output trace for weight decrease |
| weight | output | WEIGHT_W | Current synaptic weight |
| pre_trace | output | TRACE_W | Current input-side trace |
| post_trace | output | TRACE_W | Current output-side trace |

## Verification
Both traces are registered outputs, so a wrong bump, a wrong clip or a wrong shift count shows at `pre_trace` or `post_trace` on the very next clock. A wrong weight amount or a wrong update order shows at `weight` one clock after the spike that caused it. The weight never corrects itself, so such an error stays visible until reset. The stimulus table leads the traces through bump, decay and clipping, with spike pairs in both orders. The directed tests then drive the weight to its floor, so that applying the two updates in the wrong order in a coincident-spike cycle changes the final value.

// File: rtl/stdp_pkg.sv
package stdp_pkg;

   localparam int NUM_TRACES = 2;

   typedef enum logic {
      TR_PRE  = 1'b0,
      TR_POST = 1'b1
   } trace_sel_e;

endpackage

// File: rtl/stdp_trace_reg.sv
module stdp_trace_reg #(
   parameter int TRACE_W    = 8,
   parameter int SHIFT_W    = 3,
   parameter int TRACE_STEP = 64
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               bump,
   input  logic               tick,
   input  logic [SHIFT_W-1:0] shift_amt,
   output logic [TRACE_W-1:0] trace
);

   localparam logic [TRACE_W-1:0] STEP_V = TRACE_W'(TRACE_STEP);
   localparam logic [TRACE_W-1:0] MAX_V  = {TRACE_W{1'b1}};

   if (TRACE_STEP < 1 || TRACE_STEP > (2**TRACE_W) - 1) begin : g_bad_step
      $error("TRACE_STEP must fit inside the trace width and be nonzero");
   end

   logic [TRACE_W-1:0] decayed;
   logic [TRACE_W:0]   bumped;
   logic [TRACE_W-1:0] trace_nxt;

   always_comb begin
      decayed   = tick ? (trace >> shift_amt) : trace;
      bumped    = {1'b0, decayed} + {1'b0, STEP_V};
      if (bump) begin
         trace_nxt = bumped[TRACE_W] ? MAX_V : bumped[TRACE_W-1:0];
      end else begin
         trace_nxt = decayed;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         trace <= '0;
      end else begin
         trace <= trace_nxt;
      end
   end

endmodule

// File: rtl/stdp_gain_scale.sv
module stdp_gain_scale #(
   parameter int TRACE_W    = 8,
   parameter int GAIN_W     = 4,
   parameter int GAIN_SHIFT = 4,
   parameter int WEIGHT_W   = 8
) (
   input  logic [TRACE_W-1:0]  trace,
   input  logic [GAIN_W-1:0]   gain,
   output logic [WEIGHT_W-1:0] amount
);

   localparam int PROD_W   = TRACE_W + GAIN_W;
   localparam int SCALED_W = PROD_W - GAIN_SHIFT;

   if (GAIN_SHIFT < 0 || SCALED_W < 1) begin : g_bad_shift
      $error("GAIN_SHIFT must leave at least one product bit");
   end

   logic [PROD_W-1:0]   prod;
   logic [SCALED_W-1:0] scaled;

   assign prod = PROD_W'(trace) * PROD_W'(gain);

   if (GAIN_SHIFT == 0) begin : g_unscaled
      assign scaled = prod;
   end else begin : g_scaled
      assign scaled = prod[PROD_W-1:GAIN_SHIFT];
   end

   if (SCALED_W > WEIGHT_W) begin : g_clip
      assign amount = (|scaled[SCALED_W-1:WEIGHT_W]) ? {WEIGHT_W{1'b1}}
                                                     : scaled[WEIGHT_W-1:0];
   end else begin : g_fit
      assign amount = WEIGHT_W'(scaled);
   end

endmodule

// File: rtl/stdp_weight_rmw.sv
module stdp_weight_rmw #(
   parameter int WEIGHT_W    = 8,
   parameter int WEIGHT_INIT = 128
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                learn_en,
   input  logic                dep_req,
   input  logic                pot_req,
   input  logic [WEIGHT_W-1:0] dep_amt,
   input  logic [WEIGHT_W-1:0] pot_amt,
   output logic [WEIGHT_W-1:0] weight
);

   localparam logic [WEIGHT_W-1:0] W_MAX  = {WEIGHT_W{1'b1}};
   localparam logic [WEIGHT_W-1:0] W_RST  = WEIGHT_W'(WEIGHT_INIT);

   if (WEIGHT_INIT < 0 || WEIGHT_INIT > (2**WEIGHT_W) - 1) begin : g_bad_init
      $error("WEIGHT_INIT must be representable in the weight width");
   end

   logic [WEIGHT_W-1:0] after_dep;
   logic [WEIGHT_W:0]   pot_sum;
   logic [WEIGHT_W-1:0] after_pot;
   logic [WEIGHT_W-1:0] dep_eff;
   logic [WEIGHT_W-1:0] pot_eff;

   always_comb begin
      dep_eff   = dep_req ? dep_amt : '0;
      pot_eff   = pot_req ? pot_amt : '0;
      after_dep = (dep_eff > weight) ? '0 : (weight - dep_eff);
      pot_sum   = {1'b0, after_dep} + {1'b0, pot_eff};
      after_pot = pot_sum[WEIGHT_W] ? W_MAX : pot_sum[WEIGHT_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         weight <= W_RST;
      end else if (learn_en) begin
         weight <= after_pot;
      end
   end

endmodule

// File: rtl/stdp_synapse_learner.sv
module stdp_synapse_learner
   import stdp_pkg::*;
#(
   parameter int WEIGHT_W    = 8,
   parameter int TRACE_W     = 8,
   parameter int SHIFT_W     = 3,
   parameter int GAIN_W      = 4,
   parameter int GAIN_SHIFT  = 4,
   parameter int TRACE_STEP  = 64,
   parameter int WEIGHT_INIT = 128
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                learn_en,
   input  logic                pre_spike,
   input  logic                post_spike,
   input  logic                decay_tick,
   input  logic [SHIFT_W-1:0]  pre_shift,
   input  logic [SHIFT_W-1:0]  post_shift,
   input  logic [GAIN_W-1:0]   pot_gain,
   input  logic [GAIN_W-1:0]   dep_gain,
   output logic [WEIGHT_W-1:0] weight,
   output logic [TRACE_W-1:0]  pre_trace,
   output logic [TRACE_W-1:0]  post_trace
);

   localparam int IDX_PRE  = int'(TR_PRE);
   localparam int IDX_POST = int'(TR_POST);

   if (WEIGHT_W < 1 || WEIGHT_W > 8) begin : g_bad_wwidth
      $error("WEIGHT_W must lie between 1 and 8 bits");
   end
   if (TRACE_W < 2) begin : g_bad_twidth
      $error("TRACE_W must be at least 2 bits");
   end
   if (SHIFT_W < 1 || GAIN_W < 1) begin : g_bad_cfg
      $error("SHIFT_W and GAIN_W must be at least 1 bit");
   end

   logic [SHIFT_W-1:0] shift_v [NUM_TRACES];
   logic               bump_v  [NUM_TRACES];
   logic [TRACE_W-1:0] trace_v [NUM_TRACES];

   assign bump_v[IDX_PRE]   = pre_spike;
   assign bump_v[IDX_POST]  = post_spike;
   assign shift_v[IDX_PRE]  = pre_shift;
   assign shift_v[IDX_POST] = post_shift;

   for (genvar i = 0; i < NUM_TRACES; i++) begin : g_trace
      stdp_trace_reg #(
         .TRACE_W    (TRACE_W),
         .SHIFT_W    (SHIFT_W),
         .TRACE_STEP (TRACE_STEP)
      ) u_trace (
         .clk       (clk),
         .rst       (rst),
         .bump      (bump_v[i]),
         .tick      (decay_tick),
         .shift_amt (shift_v[i]),
         .trace     (trace_v[i])
      );
   end

   assign pre_trace  = trace_v[IDX_PRE];
   assign post_trace = trace_v[IDX_POST];

   logic [WEIGHT_W-1:0] pot_amt;
   logic [WEIGHT_W-1:0] dep_amt;

   stdp_gain_scale #(
      .TRACE_W    (TRACE_W),
      .GAIN_W     (GAIN_W),
      .GAIN_SHIFT (GAIN_SHIFT),
      .WEIGHT_W   (WEIGHT_W)
   ) u_pot_scale (
      .trace  (trace_v[IDX_PRE]),
      .gain   (pot_gain),
      .amount (pot_amt)
   );

   stdp_gain_scale #(
      .TRACE_W    (TRACE_W),
      .GAIN_W     (GAIN_W),
      .GAIN_SHIFT (GAIN_SHIFT),
      .WEIGHT_W   (WEIGHT_W)
   ) u_dep_scale (
      .trace  (trace_v[IDX_POST]),
      .gain   (dep_gain),
      .amount (dep_amt)
   );

   stdp_weight_rmw #(
      .WEIGHT_W    (WEIGHT_W),
      .WEIGHT_INIT (WEIGHT_INIT)
   ) u_weight (
      .clk      (clk),
      .rst      (rst),
      .learn_en (learn_en),
      .dep_req  (pre_spike),
      .pot_req  (post_spike),
      .dep_amt  (dep_amt),
      .pot_amt  (pot_amt),
      .weight   (weight)
   );

endmodule

// File: rtl/stdp_synapse_learner_chk.sv
module stdp_synapse_learner_chk #(
   parameter int WEIGHT_W = 8,
   parameter int TRACE_W  = 8,
   parameter int SHIFT_W  = 3
) (
   input logic                clk,
   input logic                rst,
   input logic                learn_en,
   input logic                pre_spike,
   input logic                post_spike,
   input logic                decay_tick,
   input logic [SHIFT_W-1:0]  pre_shift,
   input logic [SHIFT_W-1:0]  post_shift,
   input logic [WEIGHT_W-1:0] weight,
   input logic [TRACE_W-1:0]  pre_trace,
   input logic [TRACE_W-1:0]  post_trace
);

   localparam logic [TRACE_W-1:0] T_MAX = {TRACE_W{1'b1}};

   p_bump_rises_r2: assert property (@(posedge clk) disable iff (rst)
      (pre_spike && !decay_tick && pre_trace != T_MAX) |=> pre_trace > $past(pre_trace));

   p_bump_clips_r2: assert property (@(posedge clk) disable iff (rst)
      (post_spike && !decay_tick && post_trace == T_MAX) |=> post_trace == T_MAX);

   p_pre_decay_r3: assert property (@(posedge clk) disable iff (rst)
      (decay_tick && !pre_spike) |=> pre_trace == ($past(pre_trace) >> $past(pre_shift)));

   p_post_decay_r3: assert property (@(posedge clk) disable iff (rst)
      (decay_tick && !post_spike) |=> post_trace == ($past(post_trace) >> $past(post_shift)));

   p_trace_idle_r3: assert property (@(posedge clk) disable iff (rst)
      (!decay_tick && !pre_spike && !post_spike) |=> ($stable(pre_trace) && $stable(post_trace)));

   p_pot_no_drop_r4: assert property (@(posedge clk) disable iff (rst)
      (learn_en && post_spike && !pre_spike) |=> weight >= $past(weight));

   p_dep_no_rise_r5: assert property (@(posedge clk) disable iff (rst)
      (learn_en && pre_spike && !post_spike) |=> weight <= $past(weight));

   p_frozen_r7: assert property (@(posedge clk) disable iff (rst)
      (!learn_en) |=> $stable(weight));

   p_no_spike_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (!pre_spike && !post_spike) |=> $stable(weight));

endmodule

bind stdp_synapse_learner stdp_synapse_learner_chk #(
   .WEIGHT_W (WEIGHT_W),
   .TRACE_W  (TRACE_W),
   .SHIFT_W  (SHIFT_W)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .learn_en   (learn_en),
   .pre_spike  (pre_spike),
   .post_spike (post_spike),
   .decay_tick (decay_tick),
   .pre_shift  (pre_shift),
   .post_shift (post_shift),
   .weight     (weight),
   .pre_trace  (pre_trace),
   .post_trace (post_trace)
);

// File: tb/stdp_synapse_learner_bench.sv
module stdp_synapse_learner_bench;

   logic       clk = 1'b0;
   logic       rst;
   logic       learn_en;
   logic       pre_spike;
   logic       post_spike;
   logic       decay_tick;
   logic [2:0] pre_shift;
   logic [2:0] post_shift;
   logic [3:0] pot_gain;
   logic [3:0] dep_gain;
   logic [7:0] weight;
   logic [7:0] pre_trace;
   logic [7:0] post_trace;

   int n_checks = 0;
   int n_errors = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   stdp_synapse_learner u_stdp_synapse_learner (
      .clk        (clk),
      .rst        (rst),
      .learn_en   (learn_en),
      .pre_spike  (pre_spike),
      .post_spike (post_spike),
      .decay_tick (decay_tick),
      .pre_shift  (pre_shift),
      .post_shift (post_shift),
      .pot_gain   (pot_gain),
      .dep_gain   (dep_gain),
      .weight     (weight),
      .pre_trace  (pre_trace),
      .post_trace (post_trace)
   );

   typedef struct packed {
      logic       learn;
      logic       pre;
      logic       post;
      logic       tick;
      logic [7:0] exp_w;
      logic [7:0] exp_pre;
      logic [7:0] exp_post;
      logic [7:0] req;
   } vec_t;

   // Gains: pot 8/16, dep 4/16; shifts: input trace 1, output trace 2.
   localparam vec_t TAB [14] = '{
      '{1'b1, 1'b1, 1'b0, 1'b0, 8'd128, 8'd64,  8'd0,   8'd2},
      '{1'b1, 1'b0, 1'b1, 1'b0, 8'd160, 8'd64,  8'd64,  8'd4},
      '{1'b1, 1'b0, 1'b0, 1'b1, 8'd160, 8'd32,  8'd16,  8'd3},
      '{1'b1, 1'b1, 1'b0, 1'b0, 8'd156, 8'd96,  8'd16,  8'd5},
      '{1'b1, 1'b0, 1'b1, 1'b0, 8'd204, 8'd96,  8'd80,  8'd4},
      '{1'b1, 1'b0, 1'b1, 1'b0, 8'd252, 8'd96,  8'd144, 8'd4},
      '{1'b1, 1'b0, 1'b1, 1'b0, 8'd255, 8'd96,  8'd208, 8'd4},
      '{1'b1, 1'b0, 1'b1, 1'b0, 8'd255, 8'd96,  8'd255, 8'd2},
      '{1'b0, 1'b1, 1'b0, 1'b0, 8'd255, 8'd160, 8'd255, 8'd7},
      '{1'b1, 1'b1, 1'b0, 1'b0, 8'd192, 8'd224, 8'd255, 8'd5},
      '{1'b1, 1'b1, 1'b0, 1'b0, 8'd129, 8'd255, 8'd255, 8'd2},
      '{1'b1, 1'b1, 1'b0, 1'b1, 8'd66,  8'd191, 8'd63,  8'd3},
      '{1'b1, 1'b1, 1'b0, 1'b0, 8'd51,  8'd255, 8'd63,  8'd5},
      '{1'b1, 1'b0, 1'b0, 1'b0, 8'd51,  8'd255, 8'd63,  8'd8}
   };

   task automatic check(input string what, input int req, input int act, input int exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic l, input logic p, input logic q, input logic t);
      @(negedge clk);
      learn_en   = l;
      pre_spike  = p;
      post_spike = q;
      decay_tick = t;
      @(posedge clk);
      #1;
      @(negedge clk);
      pre_spike  = 1'b0;
      post_spike = 1'b0;
      decay_tick = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      @(posedge clk);
      #1;
      check("weight in reset (R1)", 1, weight, 128);
      check("pre trace in reset (R1)", 1, pre_trace, 0);
      check("post trace in reset (R1)", 1, post_trace, 0);
      @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      rst        = 1'b1;
      learn_en   = 1'b0;
      pre_spike  = 1'b0;
      post_spike = 1'b0;
      decay_tick = 1'b0;
      pre_shift  = 3'd1;
      post_shift = 3'd2;
      pot_gain   = 4'd8;
      dep_gain   = 4'd4;

      do_reset();

      for (int i = 0; i < 14; i++) begin
         drive(TAB[i].learn, TAB[i].pre, TAB[i].post, TAB[i].tick);
         check($sformatf("row %0d weight", i), int'(TAB[i].req), weight, TAB[i].exp_w);
         check($sformatf("row %0d pre trace", i), int'(TAB[i].req), pre_trace, TAB[i].exp_pre);
         check($sformatf("row %0d post trace", i), int'(TAB[i].req), post_trace, TAB[i].exp_post);
      end

      // Ordering corner: weight on the floor, coincident spikes (R6)
      do_reset();
      dep_gain = 4'd15;
      for (int k = 0; k < 4; k++) drive(1'b0, 1'b0, 1'b1, 1'b0);
      check("output trace clipped (R2)", 2, post_trace, 255);
      check("weight frozen while learning off (R7)", 7, weight, 128);
      drive(1'b1, 1'b1, 1'b0, 1'b0);
      check("decrease clips at zero (R5)", 5, weight, 0);
      check("input trace after bump (R2)", 2, pre_trace, 64);
      drive(1'b1, 1'b1, 1'b1, 1'b0);
      check("decrease then increase (R6)", 6, weight, 32);
      check("input trace after coincident bump (R6)", 6, pre_trace, 128);
      check("output trace stays clipped (R6)", 6, post_trace, 255);
      drive(1'b1, 1'b0, 1'b0, 1'b1);
      check("tick without spike keeps weight (R8)", 8, weight, 32);
      check("input trace decayed (R3)", 3, pre_trace, 64);
      check("output trace decayed (R3)", 3, post_trace, 63);

      // Reset in mid-run restores the start state (R1)
      do_reset();

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

endmodule